// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits between two independent memory ports and a shared array. Each cycle it looks at the active-low chip select and the address of both ports. A collision exists only when both ports are selected and both point at the same word. In that case one port is given the location. The other port sees an active-low busy flag, and its write strobe toward the array is held inactive.

Ownership follows arrival order. A port counts as newly arrived in a cycle if it was deselected in the previous cycle or if its address changed since then. A port that was already sitting on the location keeps it while its select and address stay unchanged. The later port is made busy, whether it got there by lowering its select onto the matching address or by moving its address onto the one the other port holds. When both ports arrive in the same cycle, a priority token settles the tie. The token favours port A first and flips after every tie.

The busy, grant and masked write outputs are combinational functions of the current inputs and a small amount of registered history. Busy therefore appears in the cycle the collision begins and is gone in the cycle it ends.

Top module: `dual_port_collision_arbiter`

## Requirements
- R1: Busy (active low) is driven on a port only when both `a_cs_n` and `b_cs_n` are low and `a_addr` equals `b_addr`. In every other cycle both busy outputs are high.
- R2: In every collision cycle exactly one of `a_busy_n` and `b_busy_n` is low.
- R3: A port whose chip select is high has its busy output high and its grant output low.
- R4: If one port was selected in the previous cycle with its current address, and the other port is newly arrived, the newly arrived port is the one made busy. A port is newly arrived if it was deselected in the previous cycle or its address differs from the previous cycle. This holds whether the new port's select fell onto the matching address or its address moved onto the other port's address.
- R5: A port that wins a collision keeps the location, with its busy high, in every following cycle where its select stays low and its address is unchanged. This holds even if the other port leaves and comes back.
- R6: When both ports are newly arrived in the same collision cycle, port A wins the first such tie after reset. The winner alternates on each later tie.
- R7: Busy asserts in the same cycle the collision begins and deasserts in the same cycle it ends, with no added cycle of latency.
- R8: `x_grant` equals chip select low and busy high. `x_mem_we_n` equals `x_we_n` when the port is granted, and is forced high when it is not.
- R9: Reset (`rst_n` low) clears the arrival history and sets the tie token back to favour port A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_we_n | input | 1 | Port A write strobe, active low |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_we_n | input | 1 | Port B write strobe, active low |
| a_busy_n | output | 1 | Port A lost the collision, active low |
| b_busy_n | output | 1 | Port B lost the collision, active low |
| a_grant | output | 1 | Port A may access the array this cycle |
| b_grant | output | 1 | Port B may access the array this cycle |
| a_mem_we_n | output | 1 | Port A write strobe toward the array, masked when not granted |
| b_mem_we_n | output | 1 | Port B write strobe toward the array, masked when not granted |

## Verification
Some properties are checked by assertions on every cycle:
- busy appears only on a real address match with both ports selected;
- a collision always has exactly one loser;
- a deselected port is never busy or granted;
- a busy port never reaches the array with a write;
- an owner whose select and address stay unchanged keeps the location into the next cycle.

The tie token flipping after each tie is also asserted. Other behaviour can only be shown by the bench's scenarios, checked against a behavioural model on every clock:
- which port wins in each arrival order, including the two ways busy can be triggered;
- the order of tie winners across several ties;
- the token returning to port A after a mid-run reset;
- busy releasing in the same cycle the collision ends.

// File: rtl/dpc_arb_pkg.sv
package dpc_arb_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_A    = 2'd1,
      OWN_B    = 2'd2
   } owner_e;

   localparam int NUM_PORTS = 2;
endpackage

// File: rtl/dpc_port_history.sv
module dpc_port_history #(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              fresh
);
   logic              seen_q;
   logic [ADDR_W-1:0] addr_q;

   // Remember whether the port was selected last cycle and where it pointed.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         addr_q <= '0;
      end else begin
         seen_q <= ~cs_n;
         addr_q <= addr;
      end
   end

   assign fresh = ~cs_n & (~seen_q | (addr_q != addr));

   // A port that was idle last cycle always counts as a new arrival.
   AST_ARRIVAL_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (cs_n || fresh));                                         // R4
endmodule

// File: rtl/dpc_owner_pick.sv
module dpc_owner_pick
   import dpc_arb_pkg::*;
#(
   parameter bit ALT_TIE = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   coll,
   input  logic   fresh_a,
   input  logic   fresh_b,
   output owner_e owner
);
   owner_e owner_q;
   logic   tie;
   logic   tie_pick_b;

   generate
      if (ALT_TIE) begin : g_alt
         logic token_q;
         always_ff @(posedge clk) begin
            if (!rst_n)   token_q <= 1'b0;
            else if (tie) token_q <= ~token_q;
         end
         assign tie_pick_b = token_q;

         AST_TIE_TOKEN_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
            tie |=> (tie_pick_b != $past(tie_pick_b)));                 // R6
      end else begin : g_fixed
         assign tie_pick_b = 1'b0;
      end
   endgenerate

   always_comb begin
      tie   = 1'b0;
      owner = OWN_NONE;
      if (coll) begin
         if (owner_q == OWN_A && !fresh_a)      owner = OWN_A;
         else if (owner_q == OWN_B && !fresh_b) owner = OWN_B;
         else if (!fresh_a && fresh_b)          owner = OWN_A;
         else if (fresh_a && !fresh_b)          owner = OWN_B;
         else begin
            tie   = 1'b1;
            owner = tie_pick_b ? OWN_B : OWN_A;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= owner;
   end
endmodule

// File: rtl/dual_port_collision_arbiter.sv
module dual_port_collision_arbiter
   import dpc_arb_pkg::*;
#(
   parameter int ADDR_W  = 14,
   parameter bit ALT_TIE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_cs_n,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_we_n,
   input  logic              b_cs_n,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_we_n,
   output logic              a_busy_n,
   output logic              b_busy_n,
   output logic              a_grant,
   output logic              b_grant,
   output logic              a_mem_we_n,
   output logic              b_mem_we_n
);
   localparam int NP = NUM_PORTS;

   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("dual_port_collision_arbiter: ADDR_W must be at least 1");
      end
   endgenerate

   logic              cs_n_v  [NP];
   logic [ADDR_W-1:0] addr_v  [NP];
   logic              fresh_v [NP];
   logic              coll;
   owner_e            owner;

   assign cs_n_v[0] = a_cs_n;
   assign cs_n_v[1] = b_cs_n;
   assign addr_v[0] = a_addr;
   assign addr_v[1] = b_addr;

   generate
      for (genvar p = 0; p < NP; p++) begin : g_hist
         dpc_port_history #(.ADDR_W(ADDR_W)) u_hist (
            .clk   (clk),
            .rst_n (rst_n),
            .cs_n  (cs_n_v[p]),
            .addr  (addr_v[p]),
            .fresh (fresh_v[p])
         );
      end
   endgenerate

   assign coll = ~a_cs_n & ~b_cs_n & (a_addr == b_addr);

   dpc_owner_pick #(.ALT_TIE(ALT_TIE)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .coll    (coll),
      .fresh_a (fresh_v[0]),
      .fresh_b (fresh_v[1]),
      .owner   (owner)
   );

   assign a_busy_n   = ~(coll && owner == OWN_B);
   assign b_busy_n   = ~(coll && owner == OWN_A);
   assign a_grant    = ~a_cs_n & a_busy_n;
   assign b_grant    = ~b_cs_n & b_busy_n;
   assign a_mem_we_n = a_we_n | ~a_grant;
   assign b_mem_we_n = b_we_n | ~b_grant;

   AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_busy_n || !b_busy_n) |-> (!a_cs_n && !b_cs_n && a_addr == b_addr)); // R1
   AST_SINGLE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_cs_n && !b_cs_n && a_addr == b_addr) |-> (a_busy_n != b_busy_n));   // R2
   AST_IDLE_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      a_cs_n |-> (a_busy_n && !a_grant));                                     // R3
   AST_IDLE_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      b_cs_n |-> (b_busy_n && !b_grant));                                     // R3
   AST_A_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !a_busy_n |-> a_mem_we_n);                                              // R8
   AST_B_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !b_busy_n |-> b_mem_we_n);                                              // R8
   AST_A_KEEPS_LOCATION: assert property (@(posedge clk) disable iff (!rst_n)
      (coll && a_busy_n) |=>
         (!(coll && $stable(a_addr) && $stable(a_cs_n)) || a_busy_n));        // R5
   AST_B_KEEPS_LOCATION: assert property (@(posedge clk) disable iff (!rst_n)
      (coll && b_busy_n) |=>
         (!(coll && $stable(b_addr) && $stable(b_cs_n)) || b_busy_n));        // R5
endmodule

// File: tb/test_dual_port_collision_arbiter.sv
module test_dual_port_collision_arbiter;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          a_cs_n, b_cs_n, a_we_n, b_we_n;
   logic [AW-1:0] a_addr, b_addr;
   logic          a_busy_n, b_busy_n, a_grant, b_grant, a_mem_we_n, b_mem_we_n;

   int n_tests = 0;
   int n_fail  = 0;

   // behavioural reference state
   int          m_prev_a, m_prev_b, m_owner, m_token;
   logic [AW-1:0] m_addr_a, m_addr_b;
   // sampled actual values of the last cycle
   logic s_abusy, s_bbusy, s_agnt, s_bgnt, s_awe, s_bwe;

   always #5 clk = ~clk;

   dual_port_collision_arbiter #(.ADDR_W(AW)) i_dual_port_collision_arbiter (
      .clk(clk), .rst_n(rst_n),
      .a_cs_n(a_cs_n), .a_addr(a_addr), .a_we_n(a_we_n),
      .b_cs_n(b_cs_n), .b_addr(b_addr), .b_we_n(b_we_n),
      .a_busy_n(a_busy_n), .b_busy_n(b_busy_n),
      .a_grant(a_grant), .b_grant(b_grant),
      .a_mem_we_n(a_mem_we_n), .b_mem_we_n(b_mem_we_n));

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic model_reset();
      m_prev_a = 0; m_prev_b = 0; m_owner = 0; m_token = 0;
      m_addr_a = '0; m_addr_b = '0;
   endtask

   // One clock: drive, compare with model, advance model at the edge.
   task automatic cyc(input logic acs, input int aad, input logic awe,
                      input logic bcs, input int bad, input logic bwe);
      bit coll, na, nb, tie;
      int own;
      logic eab, ebb, eag, ebg;
      string tag;
      @(negedge clk);
      a_cs_n = acs; a_addr = AW'(aad); a_we_n = awe;
      b_cs_n = bcs; b_addr = AW'(bad); b_we_n = bwe;
      #2;
      coll = !acs && !bcs && (AW'(aad) == AW'(bad));
      na   = !acs && (m_prev_a == 0 || m_addr_a != AW'(aad));
      nb   = !bcs && (m_prev_b == 0 || m_addr_b != AW'(bad));
      tie  = 0;
      own  = 0;
      if (coll) begin
         if (m_owner == 1 && !na)      own = 1;
         else if (m_owner == 2 && !nb) own = 2;
         else if (!na && nb)           own = 1;
         else if (na && !nb)           own = 2;
         else begin tie = 1; own = (m_token != 0) ? 2 : 1; end
      end
      eab = !(own == 2);
      ebb = !(own == 1);
      eag = !acs && eab;
      ebg = !bcs && ebb;
      tag = coll ? (tie ? "R6" : "R4") : "R1";
      chk(tag, "a_busy_n", a_busy_n, eab);
      chk(tag, "b_busy_n", b_busy_n, ebb);
      chk("R8", "a_grant", a_grant, eag);
      chk("R8", "b_grant", b_grant, ebg);
      chk("R8", "a_mem_we_n", a_mem_we_n, awe | !eag);
      chk("R8", "b_mem_we_n", b_mem_we_n, bwe | !ebg);
      s_abusy = a_busy_n; s_bbusy = b_busy_n; s_agnt = a_grant;
      s_bgnt = b_grant; s_awe = a_mem_we_n; s_bwe = b_mem_we_n;
      @(posedge clk);
      if (!rst_n) model_reset();
      else begin
         m_prev_a = !acs; m_prev_b = !bcs;
         m_addr_a = AW'(aad); m_addr_b = AW'(bad);
         m_owner = own;
         if (tie) m_token = 1 - m_token;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, 0, 1);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      a_cs_n = 1; b_cs_n = 1; a_we_n = 1; b_we_n = 1; a_addr = '0; b_addr = '0;
      model_reset();
      do_reset();

      // R3 R9: reset state with both ports idle
      cyc(1, 0, 1, 1, 0, 1);
      chk("R3", "idle a_busy_n", s_abusy, 1'b1);
      chk("R3", "idle a_grant", s_agnt, 1'b0);
      chk("R9", "idle b_mem_we_n", s_bwe, 1'b1);

      // R1: distinct addresses never collide
      cyc(0, 3, 1, 0, 4, 1);
      chk("R1", "distinct a_busy_n", s_abusy, 1'b1);
      chk("R1", "distinct b_busy_n", s_bbusy, 1'b1);

      // R4: A sits on 5, B's select falls onto 5
      cyc(0, 5, 1, 1, 0, 1);
      cyc(0, 5, 1, 0, 5, 0);
      chk("R4", "late B busy", s_bbusy, 1'b0);
      chk("R2", "owner A not busy", s_abusy, 1'b1);
      chk("R8", "busy B write masked", s_bwe, 1'b1);
      for (int i = 0; i < 3; i++) begin
         cyc(0, 5, 1, 0, 5, 0);
         chk("R5", "B stays busy", s_bbusy, 1'b0);
      end
      // R7: release in the same cycle B moves away; both writes pass
      cyc(0, 5, 0, 0, 6, 0);
      chk("R7", "B released", s_bbusy, 1'b1);
      chk("R8", "A write passes", s_awe, 1'b0);
      chk("R8", "B write passes", s_bwe, 1'b0);
      // R5: B comes back, A still owns
      cyc(0, 5, 1, 0, 5, 1);
      chk("R5", "B busy on return", s_bbusy, 1'b0);
      chk("R5", "A keeps", s_abusy, 1'b1);

      // R4: B sits on 7, A's address moves onto 7
      cyc(0, 3, 1, 0, 7, 1);
      cyc(0, 7, 1, 0, 7, 1);
      chk("R4", "moving A busy", s_abusy, 1'b0);
      // R7 R3: B deselects, A released immediately
      cyc(0, 7, 1, 1, 7, 1);
      chk("R7", "A released", s_abusy, 1'b1);
      chk("R3", "idle B not busy", s_bbusy, 1'b1);

      // R6: ties alternate, A first
      cyc(1, 0, 1, 1, 0, 1);
      cyc(0, 9, 1, 0, 9, 1);
      chk("R6", "tie1 B loses", s_bbusy, 1'b0);
      cyc(1, 0, 1, 1, 0, 1);
      cyc(0, 9, 1, 0, 9, 1);
      chk("R6", "tie2 A loses", s_abusy, 1'b0);
      cyc(1, 0, 1, 1, 0, 1);
      cyc(0, 9, 1, 0, 9, 1);
      chk("R6", "tie3 B loses", s_bbusy, 1'b0);

      // R9: after a mid-run reset the token favours A again
      do_reset();
      cyc(0, 2, 1, 0, 2, 1);
      chk("R9", "tie after reset B loses", s_bbusy, 1'b0);

      // mixed traffic over a small address range, model compared each cycle
      for (int i = 0; i < 400; i++)
         cyc(1'($urandom_range(0, 3) == 0), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 3) == 0), $urandom_range(0, 3), 1'($urandom_range(0, 1)));

      summary();
      $finish;
   end
endmodule